// File: doc/BRIEF.md
# Processing-Element Array Region Allocator

This block sits in front of a 128x128 grid of multiply-accumulate cells and decides whether a dispatched matrix-multiply request may claim a rectangular region of that grid. Each request names a starting row and column, a row and column extent, a double-rate flag, the operand dimensions, and an identifier. The allocator checks the request against the placement rules. If the rules hold and the region is free, it grants the request and marks the region busy. Otherwise it rejects the request with a 3-bit reason code. Several small operations can then share the grid side by side.

Occupancy is kept at 32x32 granularity as a 4x4 bitmap. A per-identifier table records which cells each grant holds. A release that carries the identifier frees exactly those cells. A parameter removes the 32-wide extents, which leaves only halves and the full grid.

Top module: `tile_alloc`

## Requirements
- R1: When req_tiled_i is 0, the request is treated as start (0,0) with extent (128,128), and the position and extent inputs are ignored.
- R2: A row or column extent other than 128, 64 or 32 is rejected with reason 1 (placement).
- R3: A start row that is not a multiple of the row extent, or a start column that is not a multiple of the column extent, is rejected with reason 1.
- R4: An aligned start whose region would pass row or column 128 is rejected with reason 2 (out of range).
- R5: A stationary partition size above the row extent, or a stationary free size above the column extent, is rejected with reason 3 (operand too large).
- R6: A request with the double-rate flag set and a column extent below 128 is rejected with reason 4 (mode conflict).
- R7: A request whose region overlaps a busy cell, or whose identifier still holds a region, is rejected with reason 5 (busy). When several reasons apply, the lowest code is reported.
- R8: A grant marks every 32x32 cell of its region busy, and disjoint regions can be granted together. For example, (64,0) with extent (64,128) and (0,0) with extent (64,128) are both granted.
- R9: A release frees only the cells of its identifier, and takes effect from the next cycle. A request in the same cycle as the release still sees the cells as busy.
- R10: With ALLOW_QUARTER=0, an extent of 32 is rejected with reason 1, while extents of 64 and 128 stay legal.
- R11: Each req_valid_i produces, one clock later, exactly one of grant_o or reject_o. On a grant, reason_o is 0. Both outputs are 0 in cycles that do not follow a request, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle |
| req_tiled_i | input | 1 | Position and extent are supplied |
| req_row_start_i | input | 8 | Starting row |
| req_col_start_i | input | 8 | Starting column |
| req_row_size_i | input | 8 | Row extent |
| req_col_size_i | input | 8 | Column extent |
| req_dbl_rate_i | input | 1 | Double-rate mode flag |
| req_part_dim_i | input | 8 | Stationary partition size |
| req_free_dim_i | input | 8 | Stationary free size |
| req_id_i | input | 4 | Identifier of the grant |
| rel_valid_i | input | 1 | Release strobe |
| rel_id_i | input | 4 | Identifier to release |
| grant_o | output | 1 | Request granted |
| reject_o | output | 1 | Request rejected |
| reason_o | output | 3 | 0 none, 1 placement, 2 range, 3 operand, 4 mode, 5 busy |

## Verification
The grant or reject for a request is registered, so it appears on the first rising edge after the strobe. The bench drives each request on a falling edge and samples the outputs on the next falling edge. A release changes occupancy on its own edge, so its effect is probed by a request issued after that edge. A race case issues the request in the release cycle itself and expects busy.

// File: rtl/tile_alloc_pkg.sv
package tile_alloc_pkg;
  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_PLACE = 3'd1,
    RSN_RANGE = 3'd2,
    RSN_OPER  = 3'd3,
    RSN_MODE  = 3'd4,
    RSN_BUSY  = 3'd5
  } rsn_e;
endpackage

// File: rtl/tile_rule_chk.sv
module tile_rule_chk
  import tile_alloc_pkg::*;
#(
  parameter int ARRAY_DIM     = 128,
  parameter int SUB_DIM       = 32,
  parameter int POS_W         = 8,
  parameter int DIM_W         = 8,
  parameter bit ALLOW_QUARTER = 1'b1,
  localparam int GRID  = ARRAY_DIM / SUB_DIM,
  localparam int CELLS = GRID * GRID
) (
  input  logic             tiled_i,
  input  logic [POS_W-1:0] row_start_i,
  input  logic [POS_W-1:0] col_start_i,
  input  logic [POS_W-1:0] row_size_i,
  input  logic [POS_W-1:0] col_size_i,
  input  logic             dbl_rate_i,
  input  logic [DIM_W-1:0] part_dim_i,
  input  logic [DIM_W-1:0] free_dim_i,
  output rsn_e             rsn_o,
  output logic [CELLS-1:0] mask_o
);
  localparam logic [POS_W:0] FULL = (POS_W+1)'(ARRAY_DIM);
  localparam logic [POS_W:0] HALF = (POS_W+1)'(ARRAY_DIM/2);
  localparam logic [POS_W:0] QRTR = (POS_W+1)'(ARRAY_DIM/4);

  logic [POS_W:0] rs, cs, rz, cz, row_end, col_end;
  logic rz_ok, cz_ok, align_ok, range_ok, oper_ok, mode_ok;

  // untiled requests always claim the whole grid
  assign rs = tiled_i ? {1'b0, row_start_i} : '0;
  assign cs = tiled_i ? {1'b0, col_start_i} : '0;
  assign rz = tiled_i ? {1'b0, row_size_i}  : FULL;
  assign cz = tiled_i ? {1'b0, col_size_i}  : FULL;
  assign row_end = rs + rz;
  assign col_end = cs + cz;

  assign rz_ok = (rz == FULL) || (rz == HALF) || (ALLOW_QUARTER && rz == QRTR);
  assign cz_ok = (cz == FULL) || (cz == HALF) || (ALLOW_QUARTER && cz == QRTR);
  assign align_ok = rz_ok && cz_ok && ((rs & (rz - 1'b1)) == '0) && ((cs & (cz - 1'b1)) == '0);
  assign range_ok = (row_end <= FULL) && (col_end <= FULL);
  assign oper_ok  = ((POS_W+1)'(part_dim_i) <= rz) && ((POS_W+1)'(free_dim_i) <= cz);
  assign mode_ok  = !(dbl_rate_i && cz != FULL);

  always_comb begin
    if (!align_ok)      rsn_o = RSN_PLACE;
    else if (!range_ok) rsn_o = RSN_RANGE;
    else if (!oper_ok)  rsn_o = RSN_OPER;
    else if (!mode_ok)  rsn_o = RSN_MODE;
    else                rsn_o = RSN_NONE;
  end

  for (genvar r = 0; r < GRID; r++) begin : g_row
    for (genvar c = 0; c < GRID; c++) begin : g_col
      localparam logic [POS_W:0] R_LO = (POS_W+1)'(r*SUB_DIM);
      localparam logic [POS_W:0] C_LO = (POS_W+1)'(c*SUB_DIM);
      assign mask_o[r*GRID+c] = (R_LO >= rs) && (R_LO < row_end) &&
                                (C_LO >= cs) && (C_LO < col_end);
    end
  end
endmodule

// File: rtl/tile_occ_tbl.sv
module tile_occ_tbl #(
  parameter int CELLS = 16,
  parameter int ID_W  = 4,
  localparam int NUM_ID = 1 << ID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CELLS-1:0] cand_mask_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic             grant_i,
  input  logic             rel_valid_i,
  input  logic [ID_W-1:0]  rel_id_i,
  output logic [CELLS-1:0] occ_o,
  output logic             id_busy_o
);
  logic [CELLS-1:0] held_q [NUM_ID];
  logic [CELLS-1:0] occ_q, rel_mask;

  assign rel_mask  = rel_valid_i ? held_q[rel_id_i] : '0;
  assign id_busy_o = |held_q[req_id_i];
  assign occ_o     = occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      for (int i = 0; i < NUM_ID; i++) held_q[i] <= '0;
    end else begin
      occ_q <= (occ_q & ~rel_mask) | (grant_i ? cand_mask_i : '0);
      if (rel_valid_i) held_q[rel_id_i] <= '0;
      if (grant_i)     held_q[req_id_i] <= cand_mask_i;
    end
  end
endmodule

// File: rtl/tile_alloc.sv
module tile_alloc
  import tile_alloc_pkg::*;
#(
  parameter int ARRAY_DIM     = 128,
  parameter int SUB_DIM       = 32,
  parameter int POS_W         = 8,
  parameter int DIM_W         = 8,
  parameter int ID_W          = 4,
  parameter bit ALLOW_QUARTER = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_tiled_i,
  input  logic [POS_W-1:0] req_row_start_i,
  input  logic [POS_W-1:0] req_col_start_i,
  input  logic [POS_W-1:0] req_row_size_i,
  input  logic [POS_W-1:0] req_col_size_i,
  input  logic             req_dbl_rate_i,
  input  logic [DIM_W-1:0] req_part_dim_i,
  input  logic [DIM_W-1:0] req_free_dim_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic             rel_valid_i,
  input  logic [ID_W-1:0]  rel_id_i,
  output logic             grant_o,
  output logic             reject_o,
  output logic [2:0]       reason_o
);
  localparam int GRID  = ARRAY_DIM / SUB_DIM;
  localparam int CELLS = GRID * GRID;

  rsn_e             rule_rsn, verdict;
  logic [CELLS-1:0] cand_mask, occ_map;
  logic             id_busy, grant_en;
  logic             grant_q, reject_q;
  rsn_e             reason_q;

  tile_rule_chk #(
    .ARRAY_DIM(ARRAY_DIM), .SUB_DIM(SUB_DIM), .POS_W(POS_W),
    .DIM_W(DIM_W), .ALLOW_QUARTER(ALLOW_QUARTER)
  ) u_rule (
    .tiled_i    (req_tiled_i),
    .row_start_i(req_row_start_i),
    .col_start_i(req_col_start_i),
    .row_size_i (req_row_size_i),
    .col_size_i (req_col_size_i),
    .dbl_rate_i (req_dbl_rate_i),
    .part_dim_i (req_part_dim_i),
    .free_dim_i (req_free_dim_i),
    .rsn_o      (rule_rsn),
    .mask_o     (cand_mask)
  );

  tile_occ_tbl #(.CELLS(CELLS), .ID_W(ID_W)) u_occ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cand_mask_i(cand_mask),
    .req_id_i   (req_id_i),
    .grant_i    (grant_en),
    .rel_valid_i(rel_valid_i),
    .rel_id_i   (rel_id_i),
    .occ_o      (occ_map),
    .id_busy_o  (id_busy)
  );

  // rule failures outrank occupancy
  always_comb begin
    if (rule_rsn != RSN_NONE)                       verdict = rule_rsn;
    else if (id_busy || |(occ_map & cand_mask))     verdict = RSN_BUSY;
    else                                            verdict = RSN_NONE;
  end
  assign grant_en = req_valid_i && (verdict == RSN_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
      reason_q <= RSN_NONE;
    end else begin
      grant_q  <= grant_en;
      reject_q <= req_valid_i && (verdict != RSN_NONE);
      reason_q <= req_valid_i ? verdict : RSN_NONE;
    end
  end

  assign grant_o  = grant_q;
  assign reject_o = reject_q;
  assign reason_o = reason_q;
endmodule

// File: rtl/tile_alloc_chk.sv
module tile_alloc_chk #(
  parameter int POS_W = 8,
  parameter int CELLS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_tiled_i,
  input logic             req_dbl_rate_i,
  input logic [POS_W-1:0] req_col_size_i,
  input logic             grant_o,
  input logic             reject_o,
  input logic [2:0]       reason_o,
  input logic [CELLS-1:0] occ_map
);
  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o));
  p_resp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (grant_o || reject_o));
  p_no_resp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o || reject_o) |-> $past(req_valid_i));
  p_grant_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> reason_o == 3'd0);
  p_reject_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (reason_o != 3'd0 && reason_o <= 3'd5));
  p_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !($past(req_dbl_rate_i) && $past(req_tiled_i) && $past(req_col_size_i) != POS_W'(128)));
  p_full_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !$past(req_tiled_i)) |-> &occ_map);
endmodule

bind tile_alloc tile_alloc_chk #(.POS_W(POS_W), .CELLS(CELLS)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_tiled_i, .req_dbl_rate_i,
  .req_col_size_i, .grant_o, .reject_o, .reason_o, .occ_map
);

// File: tb/test_tile_alloc.sv
module test_tile_alloc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld_a = 1'b0, vld_b = 1'b0;
  logic       tiled = 1'b0, dbl = 1'b0;
  logic [7:0] rs = '0, cs = '0, rz = '0, cz = '0, pd = '0, fd = '0;
  logic [3:0] id = '0, rid = '0;
  logic       rvld = 1'b0;
  logic       g_a, j_a, g_b, j_b;
  logic [2:0] c_a, c_b;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tile_alloc i_tile_alloc (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld_a), .req_tiled_i(tiled),
    .req_row_start_i(rs), .req_col_start_i(cs), .req_row_size_i(rz),
    .req_col_size_i(cz), .req_dbl_rate_i(dbl), .req_part_dim_i(pd),
    .req_free_dim_i(fd), .req_id_i(id), .rel_valid_i(rvld), .rel_id_i(rid),
    .grant_o(g_a), .reject_o(j_a), .reason_o(c_a));

  tile_alloc #(.ALLOW_QUARTER(1'b0)) i_tile_alloc_q (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld_b), .req_tiled_i(tiled),
    .req_row_start_i(rs), .req_col_start_i(cs), .req_row_size_i(rz),
    .req_col_size_i(cz), .req_dbl_rate_i(dbl), .req_part_dim_i(pd),
    .req_free_dim_i(fd), .req_id_i(id), .rel_valid_i(rvld), .rel_id_i(rid),
    .grant_o(g_b), .reject_o(j_b), .reason_o(c_b));

  task automatic check(input string rq, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got grant/reject/reason=%b expected %b", rq, act, exp);
    end
  endtask

  task automatic set_req(input bit t, input logic [7:0] r0, c0, r1, c1,
                         input bit d, input logic [7:0] p, f, input logic [3:0] i);
    tiled = t; rs = r0; cs = c0; rz = r1; cz = c1; dbl = d; pd = p; fd = f; id = i;
  endtask

  // one request; response registered at the next rising edge
  task automatic req(input string rq, input bit quarter_off, input bit t,
                     input logic [7:0] r0, c0, r1, c1, input bit d,
                     input logic [7:0] p, f, input logic [3:0] i,
                     input bit exp_g, input logic [2:0] exp_c);
    @(negedge clk);
    set_req(t, r0, c0, r1, c1, d, p, f, i);
    if (quarter_off) vld_b = 1'b1; else vld_a = 1'b1;
    @(negedge clk);
    vld_a = 1'b0; vld_b = 1'b0;
    if (quarter_off) check(rq, {g_b, j_b, c_b}, {exp_g, !exp_g, exp_c});
    else             check(rq, {g_a, j_a, c_a}, {exp_g, !exp_g, exp_c});
  endtask

  task automatic rel(input logic [3:0] i);
    @(negedge clk);
    rvld = 1'b1; rid = i;
    @(negedge clk);
    rvld = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 reset", {g_a, j_a, c_a}, 5'b0);
    @(negedge clk);
    check("R11 idle", {g_a, j_a, c_a}, 5'b0);
  endtask

  task automatic t_default;
    req("R1 untiled full", 0, 0, 8'd96, 8'd40, 8'd48, 8'd7, 0, 8'd128, 8'd128, 4'd0, 1, 3'd0);
    req("R7 overlap busy", 0, 1, 0, 0, 32, 32, 0, 1, 1, 4'd1, 0, 3'd5);
    rel(4'd0);
    req("R9 freed after release", 0, 1, 0, 0, 32, 32, 0, 1, 1, 4'd1, 1, 3'd0);
    rel(4'd1);
  endtask

  task automatic t_halves;
    req("R8 lower half", 0, 1, 64, 0, 64, 128, 0, 64, 128, 4'd1, 1, 3'd0);
    req("R8 upper half", 0, 1, 0, 0, 64, 128, 1, 64, 128, 4'd2, 1, 3'd0);
    req("R7 full grid busy", 0, 1, 32, 96, 32, 32, 0, 1, 1, 4'd3, 0, 3'd5);
    rel(4'd2);
    req("R9 other half kept", 0, 1, 96, 0, 32, 32, 0, 1, 1, 4'd3, 0, 3'd5);
    req("R9 released half", 0, 1, 32, 96, 32, 32, 0, 1, 1, 4'd3, 1, 3'd0);
    req("R7 id held", 0, 1, 0, 0, 32, 32, 0, 1, 1, 4'd3, 0, 3'd5);
    rel(4'd1); rel(4'd3);
  endtask

  task automatic t_rules;
    req("R3 row misaligned", 0, 1, 32, 0, 64, 64, 0, 1, 1, 4'd4, 0, 3'd1);
    req("R3 col misaligned", 0, 1, 0, 96, 64, 64, 0, 1, 1, 4'd4, 0, 3'd1);
    req("R2 bad size", 0, 1, 0, 0, 48, 64, 0, 1, 1, 4'd4, 0, 3'd1);
    req("R4 row past edge", 0, 1, 128, 0, 32, 32, 0, 1, 1, 4'd4, 0, 3'd2);
    req("R4 col past edge", 0, 1, 0, 128, 64, 64, 0, 1, 1, 4'd4, 0, 3'd2);
    req("R5 partition big", 0, 1, 0, 0, 64, 64, 0, 65, 1, 4'd4, 0, 3'd3);
    req("R5 free big", 0, 1, 0, 0, 64, 32, 0, 1, 33, 4'd4, 0, 3'd3);
    req("R6 dbl with col 64", 0, 1, 0, 0, 64, 64, 1, 1, 1, 4'd4, 0, 3'd4);
    req("R7 lowest code wins", 0, 1, 32, 0, 64, 64, 1, 99, 1, 4'd4, 0, 3'd1);
    req("R6 dbl full col ok", 0, 1, 64, 0, 64, 128, 1, 64, 128, 4'd4, 1, 3'd0);
    rel(4'd4);
  endtask

  task automatic t_quarter;
    req("R10 32 disabled", 1, 1, 0, 0, 32, 64, 0, 1, 1, 4'd0, 0, 3'd1);
    req("R10 64 still legal", 1, 1, 64, 64, 64, 64, 0, 1, 1, 4'd0, 1, 3'd0);
  endtask

  task automatic t_race;
    req("R1 untiled grab", 0, 0, 0, 0, 0, 0, 0, 1, 1, 4'd6, 1, 3'd0);
    @(negedge clk);
    set_req(1, 0, 0, 32, 32, 0, 1, 1, 4'd7);
    vld_a = 1'b1; rvld = 1'b1; rid = 4'd6;
    @(negedge clk);
    vld_a = 1'b0; rvld = 1'b0;
    check("R9 same-cycle release", {g_a, j_a, c_a}, {1'b0, 1'b1, 3'd5});
    req("R9 after release", 0, 1, 0, 0, 32, 32, 0, 1, 1, 4'd7, 1, 3'd0);
    rel(4'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default();
    t_halves();
    t_rules();
    t_quarter();
    t_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule